// File: doc/BRIEF.md
# Double-Width Funnel Shifter

This block shifts a 32-bit destination word left or right by a count of 0 to 31. The positions that open up are filled with bits from a second word, the source. In a left shift, the source's most significant bits move into the low end of the result. In a right shift, the source's least significant bits move into the high end. The source is only read and is never written back. The result, a carry flag and a valid pulse are registered, so a new operation may be issued every cycle and each result appears one cycle after it is issued.

The count input is wider than needed. Only its low bits are used, so the count is reduced modulo the word width. A reduced count of zero passes the destination through unchanged and leaves the carry flag as it was. Otherwise the carry flag takes the last destination bit pushed out of the word.

Top module: `fsh_top`

## Requirements
- R1: With `in_dir` = 0 (left) and reduced count n, `out_res` equals the upper W bits of the 2W-bit word {in_dst, in_src} shifted left by n. For example, n = 5 puts in_src[31:27] into bits 4..0, so the source MSB lands in bit 4.
- R2: With `in_dir` = 1 (right) and reduced count n, `out_res` equals the lower W bits of {in_src, in_dst} shifted right by n. For example, n = 8 puts in_src[7:0] into bits 31..24, so the source LSB lands in bit 24.
- R3: The reduced count is `in_cnt` modulo W: only the low log2(W) bits of `in_cnt` are used. A count of 37 therefore acts as 5.
- R4: A reduced count of 0 (for example `in_cnt` = 0 or 32) gives `out_res` = in_dst, and `out_cy` keeps the value it had before the operation.
- R5: For a nonzero reduced count n, `out_cy` becomes in_dst[W-n] on a left shift and in_dst[n-1] on a right shift.
- R6: `out_vld` is high for exactly one cycle, one clock after each cycle in which `in_vld` is high. Results come out in issue order, and back-to-back operations are allowed.
- R7: While `in_vld` is low, `out_res` and `out_cy` keep their last values.
- R8: A synchronous active-high `rst` clears `out_vld`, `out_res` and `out_cy` to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation strobe |
| in_dir | input | 1 | 0 = shift left, 1 = shift right |
| in_cnt | input | CNT_W (8) | Shift count, reduced modulo W |
| in_dst | input | W (32) | Destination word to be shifted |
| in_src | input | W (32) | Word supplying the fill bits; only read |
| out_vld | output | 1 | One-cycle result pulse |
| out_res | output | W (32) | Shifted destination |
| out_cy | output | 1 | Last bit shifted out of the destination |

## Verification
The bench targets the count boundaries: 0, 1, W-1, W and counts above W.
- Counts 0 and W: a design that does not reduce the count would clear the word, and a design that treats zero as a real shift would pull a stale bit into the carry.
- Counts 1 and W-1: these expose an off-by-one error in the carry index, or a fill window that is off by one position, in either direction.
- The two worked examples pin the ordering of the fill bits, so a design with reversed fill bits produces a mirrored field.
- Idle gaps between operations catch outputs that change without a strobe.
- A reset issued mid-run catches registers that the reset does not clear.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } fsh_dir_e;

  function automatic int unsigned stage_cnt(input int unsigned width);
    return $clog2(width);
  endfunction
endpackage

// File: rtl/fsh_cnt_norm.sv
module fsh_cnt_norm #(
  parameter int CNT_W = 8,
  parameter int SW    = 5
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [SW-1:0]    amt_o,
  output logic             zero_o
);
  // The width is a power of two, so modulo W keeps the low SW bits.
  always_comb begin
    amt_o  = cnt_i[SW-1:0];
    zero_o = (cnt_i[SW-1:0] == '0);
  end
endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel
  import fsh_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  fsh_dir_e      dir_i,
  input  logic [SW-1:0] amt_i,
  input  logic [W-1:0]  dst_i,
  input  logic [W-1:0]  src_i,
  output logic [W-1:0]  res_o,
  output logic          cy_o
);
  localparam int VW = 2*W + 1;

  // Left layout:  [2W] guard bit, [2W-1:W] dst, [W-1:0] src.
  // Right layout: [2W:W+1] src, [W:1] dst, [0] guard bit.
  logic [VW-1:0] stage [SW+1];

  always_comb begin
    if (dir_i == DIR_RIGHT) stage[0] = {src_i, dst_i, 1'b0};
    else                    stage[0] = {1'b0, dst_i, src_i};
  end

  // Logarithmic shifter: one stage per count bit, each moving by a power of two.
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    always_comb begin
      if (!amt_i[k])                stage[k+1] = stage[k];
      else if (dir_i == DIR_RIGHT)  stage[k+1] = stage[k] >> STEP;
      else                          stage[k+1] = stage[k] << STEP;
    end
  end

  always_comb begin
    if (dir_i == DIR_RIGHT) begin
      res_o = stage[SW][W:1];
      cy_o  = stage[SW][0];
    end else begin
      res_o = stage[SW][2*W-1:W];
      cy_o  = stage[SW][2*W];
    end
  end
endmodule

// File: rtl/fsh_top.sv
module fsh_top
  import fsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_dir,
  input  logic [CNT_W-1:0] in_cnt,
  input  logic [W-1:0]     in_dst,
  input  logic [W-1:0]     in_src,
  output logic             out_vld,
  output logic [W-1:0]     out_res,
  output logic             out_cy
);
  localparam int SW = stage_cnt(W);

  logic [SW-1:0] amt;
  logic          amt_zero;
  logic [W-1:0]  sh_res;
  logic          sh_cy;
  fsh_dir_e      dir;

  assign dir = fsh_dir_e'(in_dir);

  fsh_cnt_norm #(.CNT_W(CNT_W), .SW(SW)) u_cnt (
    .cnt_i  (in_cnt),
    .amt_o  (amt),
    .zero_o (amt_zero)
  );

  fsh_funnel #(.W(W), .SW(SW)) u_funnel (
    .dir_i (dir),
    .amt_i (amt),
    .dst_i (in_dst),
    .src_i (in_src),
    .res_o (sh_res),
    .cy_o  (sh_cy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_res <= '0;
      out_cy  <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_res <= amt_zero ? in_dst : sh_res;
        if (!amt_zero) out_cy <= sh_cy;
      end
    end
  end

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(out_res) && $stable(out_cy)));
  p_zero_cnt_r4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_cnt[SW-1:0] == '0) |=>
      (out_res == $past(in_dst) && out_cy == $past(out_cy)));
  p_left_one_r1: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !in_dir && in_cnt[SW-1:0] == SW'(1)) |=>
      (out_res == $past({in_dst[W-2:0], in_src[W-1]}) && out_cy == $past(in_dst[W-1])));
  p_right_one_r2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_dir && in_cnt[SW-1:0] == SW'(1)) |=>
      (out_res == $past({in_src[0], in_dst[W-1:1]}) && out_cy == $past(in_dst[0])));
endmodule

// File: tb/sim_fsh_top.sv
`timescale 1ns/100ps
module sim_fsh_top;
  localparam int W = 32;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_vld = 1'b0;
  logic             in_dir = 1'b0;
  logic [CNT_W-1:0] in_cnt = '0;
  logic [W-1:0]     in_dst = '0;
  logic [W-1:0]     in_src = '0;
  logic             out_vld;
  logic [W-1:0]     out_res;
  logic             out_cy;

  always #2.5 clk = ~clk;

  fsh_top #(.W(W), .CNT_W(CNT_W)) u0 (.*);

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           checks = 0;
  int           errors = 0;
  logic         cy_m = 1'b0;
  logic [W-1:0] last_res = '0;
  logic         last_cy = 1'b0;
  bit           mon_en = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual {cy,res}=%h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one operation and pushes the model's expected result into the scoreboard.
  task automatic op(input logic dir, input logic [CNT_W-1:0] cnt, input logic [W-1:0] d,
                    input logic [W-1:0] s, input string tag);
    int n;
    logic [2*W:0] t;
    exp_t e;
    n = int'(cnt) % W;
    if (!dir) begin
      t = {1'b0, d, s} << n;
      e.res = t[2*W-1:W];
    end else begin
      t = {s, d, 1'b0} >> n;
      e.res = t[W:1];
    end
    if (n != 0) cy_m = dir ? t[0] : t[2*W];
    else e.res = d;
    e.cy = cy_m;
    e.tag = tag;
    @(negedge clk);
    in_vld = 1'b1; in_dir = dir; in_cnt = cnt; in_dst = d; in_src = s;
    sb.push_back(e);
  endtask

  task automatic idle(input int cyc);
    @(negedge clk);
    in_vld = 1'b0;
    repeat (cyc - 1) @(negedge clk);
  endtask

  // Monitor: compares each result pulse against the scoreboard and checks that outputs hold between pulses.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_en) begin
        if (out_vld) begin
          if (sb.size() == 0) begin
            check(1'b0, "R6 pulse without operation", {out_cy, out_res}, '0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check({out_cy, out_res} === {e.cy, e.res}, e.tag, {out_cy, out_res}, {e.cy, e.res});
            last_res = e.res;
            last_cy = e.cy;
          end
        end else begin
          check({out_cy, out_res} === {last_cy, last_res}, "R7 hold while idle",
                {out_cy, out_res}, {last_cy, last_res});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({out_vld, out_cy, out_res} === '0, "R8 reset state", {out_cy, out_res}, '0);
    rst = 1'b0;
    mon_en = 1'b1;

    op(1'b0, 8'd5, 32'h0000_0001, 32'hC800_0000, "R1 left by 5, source MSB in bit 4");
    op(1'b1, 8'd8, 32'hFFFF_FFFF, 32'h0000_0001, "R2 right by 8, source LSB in bit 24");
    idle(2);
    op(1'b0, 8'd37, 32'h1234_5678, 32'h9ABC_DEF0, "R3 count 37 acts as 5");
    op(1'b1, 8'd200, 32'h8765_4321, 32'h0F0F_0F0F, "R3 count 200 acts as 8");
    op(1'b0, 8'd1, 32'h8000_0000, 32'h0000_0000, "R5 left by 1 sets carry");
    op(1'b0, 8'd0, 32'hDEAD_BEEF, 32'h1111_1111, "R4 count 0 passes dst, carry held");
    op(1'b1, 8'd32, 32'hCAFE_F00D, 32'h2222_2222, "R4 count 32 passes dst, carry held");
    op(1'b1, 8'd1, 32'h0000_0000, 32'hFFFF_FFFF, "R5 right by 1 clears carry");
    op(1'b1, 8'd31, 32'h4000_0000, 32'h8000_0001, "R5 right by 31 carry from bit 30");
    op(1'b0, 8'd31, 32'h0000_0002, 32'h7FFF_FFFF, "R5 left by 31 carry from bit 1");
    idle(3);
    for (int i = 0; i < 300; i++) begin
      op(1'($urandom), 8'($urandom), $urandom, $urandom, "R1 R2 R6 mixed stream");
      if (i % 17 == 0) idle(2);
    end
    idle(3);
    check(sb.size() == 0, "R6 every operation produced one result", W'(sb.size()), '0);

    mon_en = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({out_vld, out_cy, out_res} === '0, "R8 mid-run reset clears outputs", {out_cy, out_res}, '0);
    rst = 1'b0;
    cy_m = 1'b0; last_res = '0; last_cy = 1'b0;
    mon_en = 1'b1;
    op(1'b0, 8'd0, 32'h0BAD_CAFE, 32'h0, "R4 count 0 after reset keeps cleared carry");
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule